// File: doc/BRIEF.md
# Reset and Wakeup Power-State Controller

This block sits on an always-on slow clock. It turns three active-low reset pins into the internal reset tree of a chip: power-on, supply-fail and push-button. Each pin drives its own internal reset, and every one of those resets asserts at once and releases on a clock edge. It also runs the sequence that takes the chip from a powered-but-sleeping state to running code. A wake pin must first survive a settling period after power-on and then a glitch filter. The clock generator is then switched on, and after a fixed lock time the processor is released. Software can later park the processor in a low-activity state and bring it back with an exit event.

The power-on reset is the strongest reset. It alone clears the clock-calendar block, through a dedicated strobe. It alone clears the sequence-error flag, and it sets the cold-start flag in the 16-bit status word. A supply-fail or push-button reset only drops the chip back to its sleeping state. The wake pin has already been used in that power cycle, so the controller starts itself up again without it. The push-button is dangerous in one window: between accepting a wake and starting the processor. If it arrives there, the controller records an error and refuses to start until the next power-on reset.

All time thresholds are parameters counted in cycles of the slow clock.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: `sys_rst_o` goes to 1 immediately, with no clock edge, whenever any of `por_n`, `pfail_n`, `urst_n` is 0. Once all three are 1, it returns to 0 on exactly the second rising clock edge.
- R2: While `por_n` is 0, `sys_rst_o` and `rtc_clr_o` are 1, and after a clock edge `run_o`, `pll_en_o` and `cpu_en_o` are 0.
- R3: `rtc_clr_o` follows the power-on reset alone. It is 0 during a reset caused only by `pfail_n` or `urst_n`.
- R4: After a power-on reset, `status_o` equals 16'h8000. Bit 15 is the cold-start flag and reads 1. Every other bit, including the error flag in bit 0, reads 0.
- R5: The wake pin is accepted only after it has been high for at least FILT_CYC consecutive clock cycles. With FILT_CYC=4, pulses of 1 to 3 cycles are rejected, and pulses of 4 or more cycles are accepted. `pll_en_o` rises on the edge FILT_CYC+3 cycles after the wake pin rises.
- R6: The wake pin is not watched until SETTLE_CYC+2 cycles after the power-on reset is released. A pulse of any length that ends before then is discarded.
- R7: `cpu_en_o` and `run_o` rise exactly LOCK_CYC cycles after `pll_en_o` rises.
- R8: Once the running state has been reached, the wake pin has no effect until the next power-on reset. A long wake pulse in the low-activity state leaves the outputs unchanged.
- R9: `run_o` is 1 in the running and low-activity states and 0 otherwise. On the first clock edge of any system reset, `run_o`, `pll_en_o` and `cpu_en_o` all go to 0.
- R10: In the running state, a one-cycle `idle_req_i` pulse enters the low-activity state: `cpu_en_o` goes to 0 while `pll_en_o` and `run_o` stay 1. A one-cycle `idle_exit_i` pulse returns to the running state, with `cpu_en_o` at 1.
- R11: After a reset caused only by `pfail_n` or `urst_n`, if the running state had been reached since power-on, `pll_en_o` rises on the third edge after release, without any wake. `cpu_en_o` follows LOCK_CYC cycles later.
- R12: A push-button reset that arrives while the clock generator is on but the processor is not yet released sets bit 0 of `status_o`. From then on `pll_en_o` stays 0, even with a qualified wake, until the next power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pfail_n | input | 1 | Supply-fail reset, active low, asynchronous |
| urst_n | input | 1 | Push-button reset, active low, asynchronous |
| wake_i | input | 1 | Wake request, active high, asynchronous |
| idle_req_i | input | 1 | Request to enter the low-activity state |
| idle_exit_i | input | 1 | Event that leaves the low-activity state |
| sys_rst_o | output | 1 | Internal system reset, active high |
| rtc_clr_o | output | 1 | Clear strobe for the clock-calendar registers |
| run_o | output | 1 | High when running or in the low-activity state |
| pll_en_o | output | 1 | Clock generator enable |
| cpu_en_o | output | 1 | Processor enable |
| status_o | output | 16 | Bit 15 cold-start flag, bit 0 sequence error, others zero |

## Verification
Each result has its own delay. The reset output rises at once and falls two edges after release. A wake reaches the clock enable FILT_CYC+3 edges after it rises: two synchronizer flops, the filter count, and one state register. The processor enable follows exactly LOCK_CYC edges later. The bench drives at falling edges and counts rising edges from each stimulus, so it samples one cycle before each due edge and on it, proving both that nothing is early and that nothing is late. Asynchronous reset assertion is sampled one time unit after the pin falls, before any clock edge can intervene.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    ST_STBY = 2'd0,
    ST_PLL  = 2'd1,
    ST_RUN  = 2'd2,
    ST_IDLE = 2'd3
  } pwr_state_e;

  localparam int NUM_RST = 3;
  localparam int RST_POR = 0;
  localparam int RST_SYS = 1;
  localparam int RST_USR = 2;
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_o
);
  logic [STAGES-1:0] sh;

  // assert at once, release through the shift chain
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh <= '1;
    else         sh <= {sh[STAGES-2:0], 1'b0};
  end

  assign rst_o = sh[STAGES-1];
endmodule

// File: rtl/pwr_wake_filter.sv
module pwr_wake_filter #(
  parameter int FILT_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic wake_i,
  output logic ok_o
);
  localparam int FW = $clog2(FILT_CYC + 1);

  logic [1:0]    ws;
  logic [FW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) ws <= '0;
    else     ws <= {ws[0], wake_i};
  end

  always_ff @(posedge clk) begin
    if (rst || !en || !ws[1]) begin
      cnt  <= '0;
      ok_o <= 1'b0;
    end else if (cnt == FW'(FILT_CYC - 1)) begin
      ok_o <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_pkg::*;
#(
  parameter int SETTLE_CYC = 49152,
  parameter int LOCK_CYC   = 4096
) (
  input  logic clk,
  input  logic por_rst,
  input  logic sys_rst,
  input  logic usr_rst,
  input  logic wake_ok,
  input  logic idle_req_i,
  input  logic idle_exit_i,
  output logic settled_o,
  output logic run_o,
  output logic pll_en_o,
  output logic cpu_en_o,
  output logic err_o,
  output logic cold_o
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int LW = $clog2(LOCK_CYC + 1);

  pwr_state_e    state_q, state_d;
  logic [SW-1:0] settle_cnt;
  logic [LW-1:0] lock_cnt;
  logic          used_q;

  // power-on domain: survives supply-fail and push-button resets
  always_ff @(posedge clk) begin
    if (por_rst) begin
      settle_cnt <= '0;
      settled_o  <= 1'b0;
      used_q     <= 1'b0;
      err_o      <= 1'b0;
      cold_o     <= 1'b1;
    end else begin
      if (!settled_o) begin
        if (settle_cnt == SW'(SETTLE_CYC - 1)) settled_o  <= 1'b1;
        else                                   settle_cnt <= settle_cnt + 1'b1;
      end
      if (state_q == ST_RUN)              used_q <= 1'b1;
      if (usr_rst && state_q == ST_PLL)   err_o  <= 1'b1;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_STBY: if (!err_o && settled_o && (used_q || wake_ok)) state_d = ST_PLL;
      ST_PLL:  if (lock_cnt == LW'(LOCK_CYC - 1))             state_d = ST_RUN;
      ST_RUN:  if (idle_req_i)                                state_d = ST_IDLE;
      ST_IDLE: if (idle_exit_i)                               state_d = ST_RUN;
      default:                                                state_d = ST_STBY;
    endcase
  end

  // system domain: any reset returns to standby
  always_ff @(posedge clk) begin
    if (sys_rst) begin
      state_q  <= ST_STBY;
      lock_cnt <= '0;
      run_o    <= 1'b0;
      pll_en_o <= 1'b0;
      cpu_en_o <= 1'b0;
    end else begin
      state_q  <= state_d;
      lock_cnt <= (state_q == ST_PLL && state_d == ST_PLL) ? lock_cnt + 1'b1 : '0;
      run_o    <= (state_d == ST_RUN) || (state_d == ST_IDLE);
      pll_en_o <= (state_d != ST_STBY);
      cpu_en_o <= (state_d == ST_RUN);
    end
  end
endmodule

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl
  import pwr_pkg::*;
#(
  parameter int SETTLE_CYC = 49152,
  parameter int FILT_CYC   = 5,
  parameter int LOCK_CYC   = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        pfail_n,
  input  logic        urst_n,
  input  logic        wake_i,
  input  logic        idle_req_i,
  input  logic        idle_exit_i,
  output logic        sys_rst_o,
  output logic        rtc_clr_o,
  output logic        run_o,
  output logic        pll_en_o,
  output logic        cpu_en_o,
  output logic [15:0] status_o
);
  logic [NUM_RST-1:0] src_n;
  logic [NUM_RST-1:0] rst_q;
  logic               settled, wake_ok, err, cold;

  assign src_n[RST_POR] = por_n;
  assign src_n[RST_SYS] = por_n & pfail_n & urst_n;
  assign src_n[RST_USR] = urst_n;

  for (genvar g = 0; g < NUM_RST; g++) begin : g_sync
    pwr_rst_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .arst_n (src_n[g]),
      .rst_o  (rst_q[g])
    );
  end

  pwr_wake_filter #(.FILT_CYC(FILT_CYC)) i_filt (
    .clk    (clk),
    .rst    (rst_q[RST_POR]),
    .en     (settled),
    .wake_i (wake_i),
    .ok_o   (wake_ok)
  );

  pwr_seq_fsm #(.SETTLE_CYC(SETTLE_CYC), .LOCK_CYC(LOCK_CYC)) i_fsm (
    .clk         (clk),
    .por_rst     (rst_q[RST_POR]),
    .sys_rst     (rst_q[RST_SYS]),
    .usr_rst     (rst_q[RST_USR]),
    .wake_ok     (wake_ok),
    .idle_req_i  (idle_req_i),
    .idle_exit_i (idle_exit_i),
    .settled_o   (settled),
    .run_o       (run_o),
    .pll_en_o    (pll_en_o),
    .cpu_en_o    (cpu_en_o),
    .err_o       (err),
    .cold_o      (cold)
  );

  assign sys_rst_o = rst_q[RST_SYS];
  assign rtc_clr_o = rst_q[RST_POR];
  assign status_o  = {cold, 14'd0, err};
endmodule

// File: rtl/pwr_rst_ctrl_chk.sv
module pwr_rst_ctrl_chk (
  input logic        clk,
  input logic        pfail_n,
  input logic        urst_n,
  input logic        sys_rst_o,
  input logic        rtc_clr_o,
  input logic        run_o,
  input logic        pll_en_o,
  input logic        cpu_en_o,
  input logic [15:0] status_o
);
  AST_RTC_IMPLIES_SYS: assert property (@(posedge clk) disable iff (!pfail_n && !urst_n)
    rtc_clr_o |-> sys_rst_o); // R3

  AST_CPU_NEEDS_PLL: assert property (@(posedge clk) disable iff (sys_rst_o)
    cpu_en_o |-> pll_en_o); // R7

  AST_CPU_NEEDS_RUN: assert property (@(posedge clk) disable iff (sys_rst_o)
    cpu_en_o |-> run_o); // R9

  AST_RESET_DROPS: assert property (@(posedge clk) disable iff (rtc_clr_o)
    sys_rst_o |=> (!run_o && !pll_en_o && !cpu_en_o)); // R9

  AST_IDLE_KEEPS_PLL: assert property (@(posedge clk) disable iff (sys_rst_o)
    (run_o && !cpu_en_o) |-> pll_en_o); // R10

  AST_ERR_LOCKS: assert property (@(posedge clk) disable iff (rtc_clr_o)
    status_o[0] |-> !pll_en_o); // R12
endmodule

bind pwr_rst_ctrl pwr_rst_ctrl_chk i_chk (.*);

// File: tb/test_pwr_rst_ctrl.sv
module test_pwr_rst_ctrl;
  localparam int SET  = 20;
  localparam int FILT = 4;
  localparam int LOCK = 8;
  localparam int NV   = 6;
  // pulse width in cycles, expected acceptance
  localparam int VW [NV] = '{1, 2, 3, 4, 5, 9};
  localparam bit VA [NV] = '{0, 0, 0, 1, 1, 1};

  logic clk = 1'b0;
  logic por_n = 1'b0, pfail_n = 1'b1, urst_n = 1'b1;
  logic wake_i = 1'b0, idle_req_i = 1'b0, idle_exit_i = 1'b0;
  logic sys_rst_o, rtc_clr_o, run_o, pll_en_o, cpu_en_o;
  logic [15:0] status_o;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_rst_ctrl #(.SETTLE_CYC(SET), .FILT_CYC(FILT), .LOCK_CYC(LOCK)) i_pwr_rst_ctrl (
    .clk(clk), .por_n(por_n), .pfail_n(pfail_n), .urst_n(urst_n), .wake_i(wake_i),
    .idle_req_i(idle_req_i), .idle_exit_i(idle_exit_i), .sys_rst_o(sys_rst_o),
    .rtc_clr_o(rtc_clr_o), .run_o(run_o), .pll_en_o(pll_en_o), .cpu_en_o(cpu_en_o),
    .status_o(status_o));

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic power_on();
    @(negedge clk);
    por_n = 1'b0;
    step(3);
    por_n = 1'b1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    step(2);
    chk("R2 sys_rst during por", 16'(sys_rst_o), 16'd1);
    chk("R2 rtc_clr during por", 16'(rtc_clr_o), 16'd1);
    chk("R2 run during por", {13'd0, run_o, pll_en_o, cpu_en_o}, 16'd0);
    chk("R4 status after por", status_o, 16'h8000);
    por_n = 1'b1;
    step(1);
    chk("R1 sys_rst one edge after release", 16'(sys_rst_o), 16'd1);
    // R6: wake before settling ends is discarded
    wake_i = 1'b1;
    step(1);
    chk("R1 sys_rst two edges after release", 16'(sys_rst_o), 16'd0);
    step(11);
    wake_i = 1'b0;
    step(20);
    chk("R6 early wake ignored", 16'(pll_en_o), 16'd0);
    // R5 and R7: accepted wake, exact timing
    wake_i = 1'b1;
    step(FILT + 2);
    chk("R5 pll not early", 16'(pll_en_o), 16'd0);
    step(1);
    chk("R5 pll on time", 16'(pll_en_o), 16'd1);
    chk("R9 run low in pll phase", 16'(run_o), 16'd0);
    step(LOCK - 1);
    chk("R7 cpu not early", 16'(cpu_en_o), 16'd0);
    step(1);
    chk("R7 cpu on time", {14'd0, cpu_en_o, run_o}, 16'd3);
    wake_i = 1'b0;
    // R10: low-activity state
    idle_req_i = 1'b1;
    step(1);
    idle_req_i = 1'b0;
    chk("R10 idle enables", {13'd0, run_o, pll_en_o, cpu_en_o}, 16'd6);
    wake_i = 1'b1;
    step(FILT + 10);
    wake_i = 1'b0;
    chk("R8 wake in idle ignored", {13'd0, run_o, pll_en_o, cpu_en_o}, 16'd6);
    idle_exit_i = 1'b1;
    step(1);
    idle_exit_i = 1'b0;
    chk("R10 idle exit", {13'd0, run_o, pll_en_o, cpu_en_o}, 16'd7);
    // R1, R3, R9, R11: supply-fail reset and self restart
    pfail_n = 1'b0;
    #1;
    chk("R1 async assert", 16'(sys_rst_o), 16'd1);
    chk("R3 rtc untouched by pfail", 16'(rtc_clr_o), 16'd0);
    step(1);
    chk("R9 reset drops enables", {13'd0, run_o, pll_en_o, cpu_en_o}, 16'd0);
    step(2);
    pfail_n = 1'b1;
    step(2);
    chk("R11 pll still off", 16'(pll_en_o), 16'd0);
    step(1);
    chk("R11 self restart pll", 16'(pll_en_o), 16'd1);
    step(LOCK);
    chk("R11 self restart cpu", 16'(cpu_en_o), 16'd1);
    // R12: push-button inside the start window
    urst_n = 1'b0;
    #1;
    chk("R3 rtc untouched by urst", 16'(rtc_clr_o), 16'd0);
    step(2);
    urst_n = 1'b1;
    step(3);
    chk("R12 in pll phase", {14'd0, pll_en_o, cpu_en_o}, 16'd2);
    chk("R12 no error yet", status_o, 16'h8000);
    urst_n = 1'b0;
    step(1);
    chk("R12 error flag", status_o, 16'h8001);
    step(1);
    urst_n = 1'b1;
    wake_i = 1'b1;
    step(30);
    wake_i = 1'b0;
    chk("R12 lockout holds", 16'(pll_en_o), 16'd0);
    power_on();
    step(2);
    chk("R4 por clears error", status_o, 16'h8000);
    // R5: pulse-width table
    for (int i = 0; i < NV; i++) begin
      power_on();
      step(SET + 6);
      wake_i = 1'b1;
      step(VW[i]);
      wake_i = 1'b0;
      step(FILT + 6);
      chk($sformatf("R5 width %0d", VW[i]), 16'(pll_en_o), 16'(VA[i]));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule